// File: doc/BRIEF.md
# Miss Entry Pool Allocator

This block keeps track of every cache line that the first-level data cache has asked the next level for and that has not yet arrived. Two miss requests may arrive in one clock, each carrying a line address and a kind code. A request is granted an entry from a fixed pool of tracking slots and learns its slot index in the same cycle. Loads, stores and software prefetches of every hint level are treated alike. A request for a line that already owns a live slot joins that slot instead of taking a second one.

When the pool has nothing left for a request, the block lowers that port's ready and the requester keeps the request presented. Nothing is dropped. Every requester turned away in a cycle adds one to an event counter, so the counter can rise by two per clock. Fill returns name the slot they complete, may come back in any order, and free their slot in the cycle they arrive. That freed slot may be handed out again in the same cycle. One cycle later the block reports the completed slot, its line and its kind back to the requesters.

Top module: `miss_track_pool`

## Requirements
- R1: After reset all slots are free, done_valid is 0, the blocked counter is 0, and the first valid request is granted with ready 1 and slot 0.
- R2: A new line takes the lowest-numbered free slot. When both ports take new lines in one cycle, port 0 gets the lower index and port 1 the next free index above it.
- R3: At most NUM_SLOTS lines are tracked at once. A request for a new line while every slot is live sees ready 0.
- R4: A refused request is held, not discarded. It is granted in the first cycle in which a slot is available, provided the requester still presents it.
- R5: The kind code (0 load, 1 store, 2 and 3 prefetch hint levels) has no effect on allocation, merging or stalling. It is only carried through to the completion report.
- R6: In every cycle the blocked counter rises by the number of ports that present a valid request with ready 0, which is 0, 1 or 2.
- R7: A fill for a live slot frees that slot in its own cycle. On the next cycle, done_valid is 1, done_slot is the filled index, and done_line and done_kind are those of the original request.
- R8: A fill naming a slot that is not live is ignored. No completion is reported and no slot changes.
- R9: A request whose line matches a live slot is granted at once with that slot's index and does not use a new slot.
- R10: When both ports present the same untracked line in one cycle, port 0 allocates a slot and port 1 is granted that same slot.
- R11: When one free slot remains and both ports need a new slot, port 0 receives it and port 1 is refused.
- R12: Fills may complete slots in any order. Each one frees only the slot it names.
- R13: A slot freed by a fill in a cycle can be allocated to a request in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req0_valid | input | 1 | Port 0 miss request present |
| req0_line | input | LINE_AW | Port 0 line address |
| req0_kind | input | 2 | Port 0 kind: 0 load, 1 store, 2/3 prefetch |
| req0_ready | output | 1 | Port 0 granted this cycle |
| req0_slot | output | IDX_W | Slot granted to port 0 |
| req1_valid | input | 1 | Port 1 miss request present |
| req1_line | input | LINE_AW | Port 1 line address |
| req1_kind | input | 2 | Port 1 kind code |
| req1_ready | output | 1 | Port 1 granted this cycle |
| req1_slot | output | IDX_W | Slot granted to port 1 |
| fill_valid | input | 1 | A fill completes a slot |
| fill_slot | input | IDX_W | Slot index the fill completes |
| done_valid | output | 1 | Registered completion report |
| done_slot | output | IDX_W | Slot that completed |
| done_line | output | LINE_AW | Line of the completed slot |
| done_kind | output | 2 | Kind recorded at allocation |
| blocked_events | output | EVT_W | Count of refused requesters |

## Verification
The hardest situation to reach from the ports is the one where the pool is exactly full and a fill frees a slot in the same cycle that both ports compete for it. That single cycle exercises R11, R13 and R4 together. The stimulus fills all ten slots with five dual-port cycles of distinct lines and holds both ports blocked for a while so that the counter grows by two and then by one. It then fires one fill in the middle of the pool while both requests are still presented, and checks that port 0 takes the freed index and port 1 stays stalled.

// File: rtl/miss_track_pkg.sv
package miss_track_pkg;
  typedef enum logic [1:0] {
    KIND_LOAD    = 2'd0,
    KIND_STORE   = 2'd1,
    KIND_PF_NEAR = 2'd2,
    KIND_PF_FAR  = 2'd3
  } req_kind_e;

  localparam int KIND_W = 2;
endpackage

// File: rtl/slot_entry.sv
module slot_entry #(
  parameter int LINE_AW = 26,
  parameter int KIND_W  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               alloc_en,
  input  logic [LINE_AW-1:0] alloc_line,
  input  logic [KIND_W-1:0]  alloc_kind,
  input  logic               free_en,
  output logic               busy,
  output logic [LINE_AW-1:0] line,
  output logic [KIND_W-1:0]  kind
);
  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
    end else if (alloc_en) begin
      busy <= 1'b1;
    end else if (free_en) begin
      busy <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_en) begin
      line <= alloc_line;
      kind <= alloc_kind;
    end
  end
endmodule

// File: rtl/slot_picker.sv
module slot_picker #(
  parameter int N     = 10,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]     free_vec,
  output logic             found_a,
  output logic [IDX_W-1:0] idx_a,
  output logic             found_b,
  output logic [IDX_W-1:0] idx_b
);
  always_comb begin
    found_a = 1'b0;
    idx_a   = '0;
    found_b = 1'b0;
    idx_b   = '0;
    for (int i = 0; i < N; i++) begin
      if (free_vec[i]) begin
        if (!found_a) begin
          found_a = 1'b1;
          idx_a   = IDX_W'(i);
        end else if (!found_b) begin
          found_b = 1'b1;
          idx_b   = IDX_W'(i);
        end
      end
    end
  end
endmodule

// File: rtl/blocked_counter.sv
module blocked_counter #(
  parameter int EVT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       inc,
  output logic [EVT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else     count <= count + EVT_W'(inc);
  end
endmodule

// File: rtl/miss_track_pool.sv
module miss_track_pool
  import miss_track_pkg::*;
#(
  parameter int NUM_SLOTS = 10,
  parameter int LINE_AW   = 26,
  parameter int EVT_W     = 32,
  localparam int IDX_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req0_valid,
  input  logic [LINE_AW-1:0] req0_line,
  input  logic [1:0]         req0_kind,
  output logic               req0_ready,
  output logic [IDX_W-1:0]   req0_slot,
  input  logic               req1_valid,
  input  logic [LINE_AW-1:0] req1_line,
  input  logic [1:0]         req1_kind,
  output logic               req1_ready,
  output logic [IDX_W-1:0]   req1_slot,
  input  logic               fill_valid,
  input  logic [IDX_W-1:0]   fill_slot,
  output logic               done_valid,
  output logic [IDX_W-1:0]   done_slot,
  output logic [LINE_AW-1:0] done_line,
  output logic [1:0]         done_kind,
  output logic [EVT_W-1:0]   blocked_events
);
  logic [NUM_SLOTS-1:0] busy;
  logic [NUM_SLOTS-1:0] freeing;
  logic [NUM_SLOTS-1:0] live;
  logic [NUM_SLOTS-1:0] match0, match1;
  logic [NUM_SLOTS-1:0] alloc_en;
  logic [LINE_AW-1:0]   line_q  [NUM_SLOTS];
  logic [KIND_W-1:0]    kind_q  [NUM_SLOTS];
  logic [LINE_AW-1:0]   a_line  [NUM_SLOTS];
  logic [KIND_W-1:0]    a_kind  [NUM_SLOTS];

  logic             hit0, hit1;
  logic [IDX_W-1:0] hidx0, hidx1;
  logic             found_a, found_b;
  logic [IDX_W-1:0] idx_a, idx_b;
  logic             alloc0, alloc1;
  logic             fill_hit;
  logic [LINE_AW-1:0] fill_line;
  logic [KIND_W-1:0]  fill_kind;
  logic [1:0]         blk_inc;

  genvar g;
  generate
    for (g = 0; g < NUM_SLOTS; g++) begin : g_slot
      assign freeing[g] = fill_valid && (fill_slot == IDX_W'(g)) && busy[g];
      assign live[g]    = busy[g] && !freeing[g];
      assign match0[g]  = live[g] && (line_q[g] == req0_line);
      assign match1[g]  = live[g] && (line_q[g] == req1_line);
      assign alloc_en[g] = (alloc0 && req0_slot == IDX_W'(g)) ||
                           (alloc1 && req1_slot == IDX_W'(g));
      assign a_line[g] = (alloc0 && req0_slot == IDX_W'(g)) ? req0_line : req1_line;
      assign a_kind[g] = (alloc0 && req0_slot == IDX_W'(g)) ? req0_kind : req1_kind;

      slot_entry #(.LINE_AW(LINE_AW), .KIND_W(KIND_W)) u_entry (
        .clk        (clk),
        .rst        (rst),
        .alloc_en   (alloc_en[g]),
        .alloc_line (a_line[g]),
        .alloc_kind (a_kind[g]),
        .free_en    (freeing[g]),
        .busy       (busy[g]),
        .line       (line_q[g]),
        .kind       (kind_q[g])
      );
    end
  endgenerate

  // lowest matching live slot per port, plus the filled slot's contents
  always_comb begin
    hit0 = 1'b0; hidx0 = '0;
    hit1 = 1'b0; hidx1 = '0;
    fill_hit = 1'b0; fill_line = '0; fill_kind = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (match0[i]) begin hit0 = 1'b1; hidx0 = IDX_W'(i); end
      if (match1[i]) begin hit1 = 1'b1; hidx1 = IDX_W'(i); end
      if (freeing[i]) begin
        fill_hit  = 1'b1;
        fill_line = line_q[i];
        fill_kind = kind_q[i];
      end
    end
  end

  // slots freed this cycle count as available (same-cycle reuse)
  slot_picker #(.N(NUM_SLOTS), .IDX_W(IDX_W)) u_pick (
    .free_vec (~live),
    .found_a  (found_a),
    .idx_a    (idx_a),
    .found_b  (found_b),
    .idx_b    (idx_b)
  );

  always_comb begin
    req0_ready = 1'b0; req0_slot = '0; alloc0 = 1'b0;
    req1_ready = 1'b0; req1_slot = '0; alloc1 = 1'b0;
    if (req0_valid) begin
      if (hit0) begin
        req0_ready = 1'b1; req0_slot = hidx0;
      end else if (found_a) begin
        req0_ready = 1'b1; req0_slot = idx_a; alloc0 = 1'b1;
      end
    end
    if (req1_valid) begin
      if (hit1) begin
        req1_ready = 1'b1; req1_slot = hidx1;
      end else if (alloc0 && req1_line == req0_line) begin
        req1_ready = 1'b1; req1_slot = idx_a;
      end else if (alloc0) begin
        if (found_b) begin
          req1_ready = 1'b1; req1_slot = idx_b; alloc1 = 1'b1;
        end
      end else if (found_a) begin
        req1_ready = 1'b1; req1_slot = idx_a; alloc1 = 1'b1;
      end
    end
  end

  assign blk_inc = {1'b0, (req0_valid && !req0_ready)} +
                   {1'b0, (req1_valid && !req1_ready)};

  blocked_counter #(.EVT_W(EVT_W)) u_blk (
    .clk   (clk),
    .rst   (rst),
    .inc   (blk_inc),
    .count (blocked_events)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done_valid <= 1'b0;
      done_slot  <= '0;
      done_line  <= '0;
      done_kind  <= '0;
    end else begin
      done_valid <= fill_hit;
      if (fill_hit) begin
        done_slot <= fill_slot;
        done_line <= fill_line;
        done_kind <= fill_kind;
      end
    end
  end
endmodule

// File: rtl/miss_track_chk.sv
module miss_track_chk #(
  parameter int NUM_SLOTS = 10,
  parameter int LINE_AW   = 26,
  parameter int EVT_W     = 32,
  parameter int IDX_W     = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               req0_valid,
  input logic [LINE_AW-1:0] req0_line,
  input logic               req0_ready,
  input logic [IDX_W-1:0]   req0_slot,
  input logic               req1_valid,
  input logic [LINE_AW-1:0] req1_line,
  input logic               req1_ready,
  input logic [IDX_W-1:0]   req1_slot,
  input logic               fill_valid,
  input logic [IDX_W-1:0]   fill_slot,
  input logic               done_valid,
  input logic [IDX_W-1:0]   done_slot,
  input logic [EVT_W-1:0]   blocked_events,
  input logic [NUM_SLOTS-1:0] busy_vec
);
  logic [1:0] refused;
  logic       fill_live;
  assign refused   = {1'b0, (req0_valid && !req0_ready)} + {1'b0, (req1_valid && !req1_ready)};
  assign fill_live = fill_valid && (((busy_vec >> fill_slot) & NUM_SLOTS'(1)) != '0);

  AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (busy_vec == '0 && blocked_events == '0 && !done_valid)); // R1

  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (rst)
    req0_ready |-> (req0_slot < IDX_W'(NUM_SLOTS))); // R2

  AST_STALL_ONLY_FULL: assert property (@(posedge clk) disable iff (rst)
    (req0_valid && !req0_ready) |-> (&busy_vec)); // R3

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (blocked_events == $past(blocked_events) + EVT_W'($past(refused)))); // R6

  AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    fill_live |=> (done_valid && done_slot == $past(fill_slot))); // R7

  AST_FILL_IDLE: assert property (@(posedge clk) disable iff (rst)
    !fill_live |=> !done_valid); // R8

  AST_DISTINCT_GRANT: assert property (@(posedge clk) disable iff (rst)
    (req0_ready && req1_ready && req0_line != req1_line) |-> (req0_slot != req1_slot)); // R11
endmodule

bind miss_track_pool miss_track_chk #(
  .NUM_SLOTS (NUM_SLOTS),
  .LINE_AW   (LINE_AW),
  .EVT_W     (EVT_W),
  .IDX_W     (IDX_W)
) u_chk (
  .clk            (clk),
  .rst            (rst),
  .req0_valid     (req0_valid),
  .req0_line      (req0_line),
  .req0_ready     (req0_ready),
  .req0_slot      (req0_slot),
  .req1_valid     (req1_valid),
  .req1_line      (req1_line),
  .req1_ready     (req1_ready),
  .req1_slot      (req1_slot),
  .fill_valid     (fill_valid),
  .fill_slot      (fill_slot),
  .done_valid     (done_valid),
  .done_slot      (done_slot),
  .blocked_events (blocked_events),
  .busy_vec       (busy)
);

// File: tb/sim_miss_track_pool.sv
module sim_miss_track_pool;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int N  = 10;
  localparam int AW = 26;
  localparam int EW = 32;
  localparam int IW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic r0v = 1'b0, r1v = 1'b0, fv = 1'b0;
  logic [AW-1:0] r0l = '0, r1l = '0;
  logic [1:0] r0k = '0, r1k = '0;
  logic [IW-1:0] fs = '0;
  logic r0r, r1r, dv;
  logic [IW-1:0] r0s, r1s, ds;
  logic [AW-1:0] dl;
  logic [1:0] dk;
  logic [EW-1:0] cnt;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // values captured mid-cycle
  int s_r0, s_s0, s_r1, s_s1, s_dv, s_ds, s_dl, s_dk, s_cnt;

  always #2.5 clk = ~clk;

  miss_track_pool #(.NUM_SLOTS(N), .LINE_AW(AW), .EVT_W(EW)) u0 (
    .clk(clk), .rst(rst),
    .req0_valid(r0v), .req0_line(r0l), .req0_kind(r0k), .req0_ready(r0r), .req0_slot(r0s),
    .req1_valid(r1v), .req1_line(r1l), .req1_kind(r1k), .req1_ready(r1r), .req1_slot(r1s),
    .fill_valid(fv), .fill_slot(fs),
    .done_valid(dv), .done_slot(ds), .done_line(dl), .done_kind(dk),
    .blocked_events(cnt)
  );

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(bit v0, int l0, int k0, bit v1, int l1, int k1, bit f, int fsl);
    @(negedge clk);
    r0v = v0; r0l = AW'(l0); r0k = 2'(k0);
    r1v = v1; r1l = AW'(l1); r1k = 2'(k1);
    fv = f; fs = IW'(fsl);
    #1;
    s_r0 = int'(r0r); s_s0 = int'(r0s);
    s_r1 = int'(r1r); s_s1 = int'(r1s);
    s_dv = int'(dv); s_ds = int'(ds); s_dl = int'(dl); s_dk = int'(dk);
    s_cnt = int'(cnt);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; r0v = 0; r1v = 0; fv = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    cyc(0, 0, 0, 0, 0, 0, 0, 0);
    check("R1 done_valid", s_dv, 0);
    check("R1 counter", s_cnt, 0);
    cyc(1, 40, 0, 0, 0, 0, 0, 0);
    check("R1 first ready", s_r0, 1);
    check("R1 first slot", s_s0, 0);
  endtask

  task automatic t_order();
    do_reset();
    cyc(1, 100, 0, 1, 101, 3, 0, 0);
    check("R2 p0 slot", s_s0, 0);
    check("R2 p1 slot", s_s1, 1);
    cyc(1, 102, 1, 1, 103, 2, 0, 0);
    check("R5 store slot", s_s0, 2);
    check("R5 prefetch slot", s_s1, 3);
    check("R5 prefetch ready", s_r1, 1);
  endtask

  task automatic t_full();
    do_reset();
    for (int k = 0; k < 5; k++) begin
      cyc(1, 100 + 2*k, 2, 1, 101 + 2*k, 3, 0, 0);
      check("R2 fill p0", s_s0, 2*k);
      check("R2 fill p1", s_s1, 2*k + 1);
    end
    cyc(1, 200, 2, 1, 201, 3, 0, 0);
    check("R3 p0 refused", s_r0, 0);
    check("R3 p1 refused", s_r1, 0);
    check("R6 count before", s_cnt, 0);
    cyc(1, 200, 2, 0, 0, 0, 0, 0);
    check("R6 count two", s_cnt, 2);
    check("R4 still held", s_r0, 0);
    cyc(1, 200, 2, 1, 201, 3, 1, 4);
    check("R6 count three", s_cnt, 3);
    check("R11 p0 wins", s_r0, 1);
    check("R13 reuse slot", s_s0, 4);
    check("R11 p1 refused", s_r1, 0);
    cyc(0, 0, 0, 1, 201, 3, 0, 0);
    check("R7 done", s_dv, 1);
    check("R7 done slot", s_ds, 4);
    check("R7 done line", s_dl, 104);
    check("R7 done kind", s_dk, 2);
    check("R6 count four", s_cnt, 4);
    check("R4 p1 still held", s_r1, 0);
  endtask

  task automatic t_merge();
    do_reset();
    cyc(1, 50, 0, 0, 0, 0, 0, 0);
    check("R9 base", s_s0, 0);
    cyc(1, 50, 2, 1, 51, 1, 0, 0);
    check("R9 merge ready", s_r0, 1);
    check("R9 merge slot", s_s0, 0);
    check("R9 no new use", s_s1, 1);
    cyc(1, 60, 0, 1, 60, 3, 0, 0);
    check("R10 p0 slot", s_s0, 2);
    check("R10 p1 ready", s_r1, 1);
    check("R10 p1 shares", s_s1, 2);
    cyc(1, 70, 0, 0, 0, 0, 0, 0);
    check("R10 next free", s_s0, 3);
  endtask

  task automatic t_ooo();
    do_reset();
    cyc(1, 10, 0, 1, 11, 1, 0, 0);
    cyc(1, 12, 3, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 1, 2);
    cyc(0, 0, 0, 0, 0, 0, 1, 0);
    check("R12 first done", s_ds, 2);
    check("R12 first line", s_dl, 12);
    check("R12 first kind", s_dk, 3);
    cyc(0, 0, 0, 0, 0, 0, 1, 5);
    check("R12 second done", s_ds, 0);
    check("R12 second line", s_dl, 10);
    cyc(0, 0, 0, 0, 0, 0, 0, 0);
    check("R8 idle fill", s_dv, 0);
    cyc(1, 13, 0, 1, 11, 0, 0, 0);
    check("R7 freed reused", s_s0, 0);
    check("R12 slot1 kept", s_s1, 1);
    cyc(1, 12, 0, 0, 0, 0, 0, 0);
    check("R12 freed line fresh", s_s0, 2);
    cyc(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    t_reset();
    t_order();
    t_full();
    t_merge();
    t_ooo();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5ns * 20000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog act=1 exp=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule